// File: doc/BRIEF.md
# Two-Level Interrupt Entry Controller

This block sits beside an in-order pipeline and decides when the pipeline leaves its instruction stream for an interrupt handler. It watches two level-sensitive request lines, a normal one and a critical one. Each passes through a flop synchronizer first. Each is then gated by its own enable bit in the machine state word that the block holds. When the pipeline reports an instruction boundary, the block chooses one level, saves the resume address and the state word into that level's save pair, and clears the enable bits. It then sends the pipeline a redirect to the handler address.

A critical entry first raises three one-cycle abort strobes, so the pipeline drops unfinished multi-cycle operations, loads and stores, and any page-table search. The redirect follows on the next cycle. Each level has its own return strobe. A return reloads the state word and the resume address from that level's save pair only. If a request line is still high when its enable comes back, the block takes that interrupt again. Software writes to the state word pass through a plain write port.

Top module: `irq_entry_ctrl`

## Requirements
- R1: Each request line reaches the decision logic through SYNC_STAGES flops. With the default of two, a normal request raised at a boundary with its enable set gives redirect_valid three rising edges later. A critical request gives the abort strobes three edges later and redirect_valid four edges later.
- R2: A normal request is taken only while state bit EE_POS (default 15) is 1. A request that is high while EE is 0 changes nothing and is not remembered after the line falls.
- R3: A critical request is taken only while state bit CE_POS (default 17) is 1. Otherwise it changes nothing.
- R4: The redirect address is exc_base + 0x500 for a normal entry and exc_base + 0xA00 for a critical entry. The sum is taken modulo 2^ADDR_W.
- R5: When both requests are pending and enabled in the same cycle, the critical one is taken. The normal one stays untaken while EE is 0.
- R6: On a critical entry, abort_multicycle, abort_ldst and abort_walk rise together for exactly one cycle. redirect_valid follows in the next cycle. A normal entry or a return never raises them.
- R7: On entry, next_pc and the state word go into that level's save pair, and EE is cleared. A critical entry also clears CE. The other level's pair is left unchanged.
- R8: A ret_norm pulse loads the state word from the normal save pair and redirects to the normal saved address.
- R9: A ret_crit pulse loads the state word, including the old EE and CE, from the critical save pair and redirects to the critical saved address.
- R10: After a return has re-enabled a level, a request line that is still high is taken again on the next boundary.
- R11: No entry takes place while insn_boundary is 0. A pending request is taken once insn_boundary returns to 1.
- R12: Reset clears the state word, both save pairs, the abort strobes and redirect_valid. A msr_wr_en pulse loads msr_wr_data into the state word in a cycle with no entry or return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_in | input | 1 | Normal interrupt request, level, asynchronous |
| crit_irq_in | input | 1 | Critical interrupt request, level, asynchronous |
| insn_boundary | input | 1 | Pipeline is at an instruction boundary |
| next_pc | input | ADDR_W | Address at which to resume after the handler |
| exc_base | input | ADDR_W | Exception vector base |
| msr_wr_en | input | 1 | Write strobe for the state word |
| msr_wr_data | input | MSR_W | Value written to the state word |
| ret_norm | input | 1 | Return-from-normal-interrupt pulse |
| ret_crit | input | 1 | Return-from-critical-interrupt pulse |
| msr_q | output | MSR_W | Current state word |
| abort_multicycle | output | 1 | Abandon unfinished multi-cycle operations |
| abort_ldst | output | 1 | Abandon uncompleted loads and stores |
| abort_walk | output | 1 | Abandon any page-table search |
| redirect_valid | output | 1 | Fetch from redirect_pc this cycle |
| redirect_pc | output | ADDR_W | Handler or return address |
| norm_save_pc | output | ADDR_W | Normal-level saved address |
| norm_save_msr | output | MSR_W | Normal-level saved state word |
| crit_save_pc | output | ADDR_W | Critical-level saved address |
| crit_save_msr | output | MSR_W | Critical-level saved state word |

## Verification
The bench keeps the default 32-bit address and state widths, the two-stage synchronizer and enable bits 15 and 17. With these defaults the three-edge and four-edge latencies of R1 are exact numbers that the bench can count. The exception base is first 0x0000FE40, so each vector addition carries into the upper half. It is then moved to 0xFFFFF800, so the critical vector wraps around to 0x00000200. The save pairs are brought out as ports, so the bench can show that an ignored request, or the other level's entry, left a pair untouched.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  // Controller sequencing state
  typedef enum logic [0:0] {
    ST_IDLE,
    ST_CRIT_ABORT
  } entry_st_e;

  // Outcome of arbitration in one cycle
  typedef enum logic [1:0] {
    PICK_NONE,
    PICK_NORM,
    PICK_CRIT
  } pick_e;

  // Save-pair slot per level
  localparam int LVL_NORM = 0;
  localparam int LVL_CRIT = 1;
  localparam int NUM_LVL  = 2;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_entry_pkg::*;
(
  input  logic  norm_req,
  input  logic  crit_req,
  input  logic  ee,
  input  logic  ce,
  input  logic  boundary,
  input  logic  hold,
  output pick_e pick
);
  logic crit_ok;
  logic norm_ok;

  always_comb begin
    crit_ok = crit_req & ce;
    norm_ok = norm_req & ee;
    pick    = PICK_NONE;
    if (boundary && !hold) begin
      if (crit_ok)      pick = PICK_CRIT;
      else if (norm_ok) pick = PICK_NORM;
    end
  end
endmodule

// File: rtl/irq_save_pair.sv
module irq_save_pair #(
  parameter int ADDR_W = 32,
  parameter int MSR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [MSR_W-1:0]  msr_in,
  output logic [ADDR_W-1:0] pc_q,
  output logic [MSR_W-1:0]  msr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      msr_q <= '0;
    end else if (load) begin
      pc_q  <= pc_in;
      msr_q <= msr_in;
    end
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                MSR_W       = 32,
  parameter int                EE_POS      = 15,
  parameter int                CE_POS      = 17,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] NORM_OFS    = 'h500,
  parameter logic [ADDR_W-1:0] CRIT_OFS    = 'hA00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_irq_in,
  input  logic              crit_irq_in,
  input  logic              insn_boundary,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [ADDR_W-1:0] exc_base,
  input  logic              msr_wr_en,
  input  logic [MSR_W-1:0]  msr_wr_data,
  input  logic              ret_norm,
  input  logic              ret_crit,
  output logic [MSR_W-1:0]  msr_q,
  output logic              abort_multicycle,
  output logic              abort_ldst,
  output logic              abort_walk,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic [ADDR_W-1:0] norm_save_pc,
  output logic [MSR_W-1:0]  norm_save_msr,
  output logic [ADDR_W-1:0] crit_save_pc,
  output logic [MSR_W-1:0]  crit_save_msr
);

  // Handler address for a level: base plus level offset, modulo 2^ADDR_W
  function automatic logic [ADDR_W-1:0] vector_of(input logic [ADDR_W-1:0] base,
                                                  input logic [ADDR_W-1:0] ofs);
    return base + ofs;
  endfunction

  // State word as it stands inside a handler
  function automatic logic [MSR_W-1:0] entry_msr(input logic [MSR_W-1:0] cur,
                                                 input logic            clr_ce);
    logic [MSR_W-1:0] r;
    r         = cur;
    r[EE_POS] = 1'b0;
    if (clr_ce) r[CE_POS] = 1'b0;
    return r;
  endfunction

  // Synchronized request levels
  logic ext_s;
  logic crit_s;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
    .clk (clk),
    .rst_n (rst_n),
    .d   (ext_irq_in),
    .q   (ext_s)
  );

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync_crit (
    .clk (clk),
    .rst_n (rst_n),
    .d   (crit_irq_in),
    .q   (crit_s)
  );

  // Named internal events
  entry_st_e st_q;
  pick_e     pick;
  logic      idle;
  logic      hold;
  logic      take_norm;
  logic      take_crit;
  logic      do_rfi;
  logic      do_rfci;

  assign idle    = (st_q == ST_IDLE);
  assign hold    = !idle || ret_norm || ret_crit;
  assign do_rfci = idle && ret_crit;
  assign do_rfi  = idle && ret_norm && !ret_crit;

  irq_pick u_pick (
    .norm_req (ext_s),
    .crit_req (crit_s),
    .ee       (msr_q[EE_POS]),
    .ce       (msr_q[CE_POS]),
    .boundary (insn_boundary),
    .hold     (hold),
    .pick     (pick)
  );

  assign take_norm = (pick == PICK_NORM);
  assign take_crit = (pick == PICK_CRIT);

  // One save pair per level
  logic [NUM_LVL-1:0] save_ld;
  logic [ADDR_W-1:0]  save_pc  [NUM_LVL];
  logic [MSR_W-1:0]   save_msr [NUM_LVL];

  assign save_ld[LVL_NORM] = take_norm;
  assign save_ld[LVL_CRIT] = take_crit;

  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_level
    irq_save_pair #(.ADDR_W(ADDR_W), .MSR_W(MSR_W)) u_pair (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (save_ld[lv]),
      .pc_in  (next_pc),
      .msr_in (msr_q),
      .pc_q   (save_pc[lv]),
      .msr_q  (save_msr[lv])
    );
  end

  assign norm_save_pc  = save_pc[LVL_NORM];
  assign norm_save_msr = save_msr[LVL_NORM];
  assign crit_save_pc  = save_pc[LVL_CRIT];
  assign crit_save_msr = save_msr[LVL_CRIT];

  // State word: return > entry > software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msr_q <= '0;
    end else if (do_rfci) begin
      msr_q <= save_msr[LVL_CRIT];
    end else if (do_rfi) begin
      msr_q <= save_msr[LVL_NORM];
    end else if (take_crit) begin
      msr_q <= entry_msr(msr_q, 1'b1);
    end else if (take_norm) begin
      msr_q <= entry_msr(msr_q, 1'b0);
    end else if (msr_wr_en) begin
      msr_q <= msr_wr_data;
    end
  end

  // Sequencer, abort strobes and redirect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q             <= ST_IDLE;
      abort_multicycle <= 1'b0;
      abort_ldst       <= 1'b0;
      abort_walk       <= 1'b0;
      redirect_valid   <= 1'b0;
      redirect_pc      <= '0;
    end else begin
      abort_multicycle <= 1'b0;
      abort_ldst       <= 1'b0;
      abort_walk       <= 1'b0;
      redirect_valid   <= 1'b0;
      case (st_q)
        ST_CRIT_ABORT: begin
          redirect_valid <= 1'b1;
          redirect_pc    <= vector_of(exc_base, CRIT_OFS);
          st_q           <= ST_IDLE;
        end
        default: begin
          if (do_rfci) begin
            redirect_valid <= 1'b1;
            redirect_pc    <= save_pc[LVL_CRIT];
          end else if (do_rfi) begin
            redirect_valid <= 1'b1;
            redirect_pc    <= save_pc[LVL_NORM];
          end else if (take_crit) begin
            abort_multicycle <= 1'b1;
            abort_ldst       <= 1'b1;
            abort_walk       <= 1'b1;
            st_q             <= ST_CRIT_ABORT;
          end else if (take_norm) begin
            redirect_valid <= 1'b1;
            redirect_pc    <= vector_of(exc_base, NORM_OFS);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int                ADDR_W   = 32,
  parameter int                MSR_W    = 32,
  parameter int                EE_POS   = 15,
  parameter int                CE_POS   = 17,
  parameter logic [ADDR_W-1:0] NORM_OFS = 'h500,
  parameter logic [ADDR_W-1:0] CRIT_OFS = 'hA00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              take_norm,
  input logic              take_crit,
  input logic              do_rfi,
  input logic              do_rfci,
  input logic [ADDR_W-1:0] next_pc,
  input logic [ADDR_W-1:0] exc_base,
  input logic [MSR_W-1:0]  msr_q,
  input logic              abort_multicycle,
  input logic              abort_ldst,
  input logic              abort_walk,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_pc,
  input logic [ADDR_W-1:0] norm_save_pc,
  input logic [MSR_W-1:0]  norm_save_msr,
  input logic [ADDR_W-1:0] crit_save_pc,
  input logic [MSR_W-1:0]  crit_save_msr
);

  // R2
  ee_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_norm |-> msr_q[EE_POS]);

  // R3
  ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_crit |-> msr_q[CE_POS]);

  // R4
  norm_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_norm |=> redirect_valid && redirect_pc == $past(exc_base) + NORM_OFS);

  // R6
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ldst |=> !abort_ldst);

  // R6
  abort_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ldst == abort_multicycle && abort_ldst == abort_walk);

  // R6
  abort_then_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ldst |=> redirect_valid && redirect_pc == $past(exc_base) + CRIT_OFS);

  // R7
  crit_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_crit |=> crit_save_pc == $past(next_pc) && crit_save_msr == $past(msr_q)
                  && !msr_q[EE_POS] && !msr_q[CE_POS] && $stable(norm_save_pc));

  // R7
  norm_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_norm |=> norm_save_pc == $past(next_pc) && norm_save_msr == $past(msr_q)
                  && !msr_q[EE_POS] && $stable(crit_save_pc));

  // R8
  rfi_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_rfi |=> msr_q == $past(norm_save_msr) && redirect_valid
               && redirect_pc == $past(norm_save_pc));

  // R9
  rfci_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_rfci |=> msr_q == $past(crit_save_msr) && redirect_valid
                && redirect_pc == $past(crit_save_pc));

endmodule

bind irq_entry_ctrl irq_entry_chk #(
  .ADDR_W   (ADDR_W),
  .MSR_W    (MSR_W),
  .EE_POS   (EE_POS),
  .CE_POS   (CE_POS),
  .NORM_OFS (NORM_OFS),
  .CRIT_OFS (CRIT_OFS)
) u_irq_entry_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .take_norm        (take_norm),
  .take_crit        (take_crit),
  .do_rfi           (do_rfi),
  .do_rfci          (do_rfci),
  .next_pc          (next_pc),
  .exc_base         (exc_base),
  .msr_q            (msr_q),
  .abort_multicycle (abort_multicycle),
  .abort_ldst       (abort_ldst),
  .abort_walk       (abort_walk),
  .redirect_valid   (redirect_valid),
  .redirect_pc      (redirect_pc),
  .norm_save_pc     (norm_save_pc),
  .norm_save_msr    (norm_save_msr),
  .crit_save_pc     (crit_save_pc),
  .crit_save_msr    (crit_save_msr)
);

// File: tb/irq_entry_ctrl_bench.sv
`timescale 1ns/100ps
module irq_entry_ctrl_bench;

  localparam logic [31:0] BIT_EE = 32'h0000_8000;   // state bit 15
  localparam logic [31:0] BIT_CE = 32'h0002_0000;   // state bit 17
  localparam logic [31:0] OTHER  = 32'h0000_0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_irq_in = 1'b0;
  logic        crit_irq_in = 1'b0;
  logic        insn_boundary = 1'b1;
  logic [31:0] next_pc = 32'h0000_1000;
  logic [31:0] exc_base = 32'h0000_FE40;
  logic        msr_wr_en = 1'b0;
  logic [31:0] msr_wr_data = '0;
  logic        ret_norm = 1'b0;
  logic        ret_crit = 1'b0;
  logic [31:0] msr_q;
  logic        abort_multicycle, abort_ldst, abort_walk;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic [31:0] norm_save_pc, norm_save_msr, crit_save_pc, crit_save_msr;

  always #2.5 clk = ~clk;

  irq_entry_ctrl u_irq_entry_ctrl (
    .clk (clk), .rst_n (rst_n),
    .ext_irq_in (ext_irq_in), .crit_irq_in (crit_irq_in),
    .insn_boundary (insn_boundary), .next_pc (next_pc), .exc_base (exc_base),
    .msr_wr_en (msr_wr_en), .msr_wr_data (msr_wr_data),
    .ret_norm (ret_norm), .ret_crit (ret_crit),
    .msr_q (msr_q),
    .abort_multicycle (abort_multicycle), .abort_ldst (abort_ldst), .abort_walk (abort_walk),
    .redirect_valid (redirect_valid), .redirect_pc (redirect_pc),
    .norm_save_pc (norm_save_pc), .norm_save_msr (norm_save_msr),
    .crit_save_pc (crit_save_pc), .crit_save_msr (crit_save_msr)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic        crit;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;
  int   n_cmp = 0;
  int   n_bad = 0;
  int   abort_run = 0;
  logic abort_prev = 1'b0;
  bit   done = 1'b0;
  int   cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected handler and return addresses, computed here
  function automatic logic [31:0] norm_vec(input logic [31:0] b);
    logic [32:0] s;
    s = {1'b0, b} + 33'd1280;
    return s[31:0];
  endfunction
  function automatic logic [31:0] crit_vec(input logic [31:0] b);
    logic [32:0] s;
    s = {1'b0, b} + 33'd2560;
    return s[31:0];
  endfunction

  task automatic push(input logic [31:0] pc, input logic crit);
    exp_t e;
    e.pc   = pc;
    e.crit = crit;
    exp_q.push_back(e);
  endtask

  // Monitor: pops expected redirects, tracks abort strobes
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (abort_ldst) abort_run++;
      else            abort_run = 0;
      if (abort_run > 1) chk(1'b0, "R6 abort longer than one cycle", 64'(abort_run), 64'd1);
      if (!(abort_ldst == abort_multicycle && abort_ldst == abort_walk))
        chk(1'b0, "R6 abort strobes not together",
            {61'd0, abort_multicycle, abort_ldst, abort_walk}, 64'd0);
      if (redirect_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2/R3/R5/R11 unexpected redirect", 64'(redirect_pc), 64'd0);
        end else begin
          mon_e = exp_q.pop_front();
          chk(redirect_pc == mon_e.pc, "R4/R8/R9 redirect address", 64'(redirect_pc), 64'(mon_e.pc));
          chk(abort_prev == mon_e.crit, "R6 abort in cycle before redirect", 64'(abort_prev), 64'(mon_e.crit));
        end
      end
      abort_prev = abort_ldst;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_msr(input logic [31:0] v);
    @(negedge clk);
    msr_wr_en   = 1'b1;
    msr_wr_data = v;
    @(negedge clk);
    msr_wr_en   = 1'b0;
  endtask

  task automatic drain(input string tag);
    int k = 0;
    while (exp_q.size() != 0 && k < 50) begin
      @(negedge clk);
      k++;
    end
    chk(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic wait_redirect(output int lat);
    lat = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (redirect_valid) begin
        lat = k;
        break;
      end
    end
  endtask

  task automatic pulse_ret(input logic crit);
    @(negedge clk);
    if (crit) ret_crit = 1'b1;
    else      ret_norm = 1'b1;
    @(negedge clk);
    ret_crit = 1'b0;
    ret_norm = 1'b0;
  endtask

  initial begin
    int lat;
    tick(4);
    rst_n = 1'b1;
    tick(1);
    // R12 reset state
    chk(msr_q == 0, "R12 reset state word", 64'(msr_q), 64'd0);
    chk(!redirect_valid && !abort_ldst && !abort_multicycle && !abort_walk,
        "R12 reset strobes", {60'd0, redirect_valid, abort_ldst, abort_multicycle, abort_walk}, 64'd0);
    chk(norm_save_pc == 0 && crit_save_pc == 0 && norm_save_msr == 0 && crit_save_msr == 0,
        "R12 reset save pairs", 64'(norm_save_pc | crit_save_pc), 64'd0);

    // R2: request while EE=0 is ignored and not remembered
    ext_irq_in = 1'b1;
    tick(12);
    chk(norm_save_pc == 0, "R2 save pair untouched with EE clear", 64'(norm_save_pc), 64'd0);
    chk(msr_q == 0, "R2 state word untouched with EE clear", 64'(msr_q), 64'd0);
    ext_irq_in = 1'b0;
    tick(4);
    write_msr(BIT_EE | OTHER);
    tick(8);
    chk(msr_q == (BIT_EE | OTHER), "R12 software write", 64'(msr_q), 64'(BIT_EE | OTHER));
    chk(norm_save_pc == 0, "R2 dropped request not latched", 64'(norm_save_pc), 64'd0);

    // R1/R4/R7 normal entry
    next_pc = 32'h1000_2004;
    push(norm_vec(exc_base), 1'b0);
    @(negedge clk);
    ext_irq_in = 1'b1;
    wait_redirect(lat);
    chk(lat == 3, "R1 normal entry latency", 64'(lat), 64'd3);
    chk(norm_save_pc == 32'h1000_2004, "R7 normal saved address", 64'(norm_save_pc), 64'h1000_2004);
    chk(norm_save_msr == (BIT_EE | OTHER), "R7 normal saved state", 64'(norm_save_msr), 64'(BIT_EE | OTHER));
    chk(msr_q == OTHER, "R7 EE cleared on normal entry", 64'(msr_q), 64'(OTHER));
    chk(crit_save_pc == 0, "R7 critical pair untouched", 64'(crit_save_pc), 64'd0);

    // R8 normal return
    ext_irq_in = 1'b0;
    tick(4);
    push(32'h1000_2004, 1'b0);
    pulse_ret(1'b0);
    chk(msr_q == (BIT_EE | OTHER), "R8 state restored", 64'(msr_q), 64'(BIT_EE | OTHER));
    drain("R8 return redirect seen");

    // R3 critical ignored while CE=0
    crit_irq_in = 1'b1;
    tick(12);
    chk(crit_save_pc == 0, "R3 critical pair untouched with CE clear", 64'(crit_save_pc), 64'd0);
    chk(msr_q == (BIT_EE | OTHER), "R3 state unchanged with CE clear", 64'(msr_q), 64'(BIT_EE | OTHER));
    crit_irq_in = 1'b0;
    tick(4);

    // R5/R6/R7 both pending, critical wins
    write_msr(BIT_EE | BIT_CE | OTHER);
    next_pc = 32'h2000_0100;
    push(crit_vec(exc_base), 1'b1);
    @(negedge clk);
    crit_irq_in = 1'b1;
    ext_irq_in  = 1'b1;
    drain("R5 critical taken first");
    chk(crit_save_pc == 32'h2000_0100, "R7 critical saved address", 64'(crit_save_pc), 64'h2000_0100);
    chk(crit_save_msr == (BIT_EE | BIT_CE | OTHER), "R7 critical saved state",
        64'(crit_save_msr), 64'(BIT_EE | BIT_CE | OTHER));
    chk(msr_q == OTHER, "R7 EE and CE cleared on critical entry", 64'(msr_q), 64'(OTHER));
    chk(norm_save_pc == 32'h1000_2004, "R7 normal pair untouched by critical entry",
        64'(norm_save_pc), 64'h1000_2004);
    tick(10);   // R5: normal held off while EE=0 (monitor flags any redirect)

    // R9/R10 critical return, then pending normal taken again
    crit_irq_in = 1'b0;
    tick(4);
    next_pc = 32'h3000_0000;
    push(32'h2000_0100, 1'b0);
    push(norm_vec(exc_base), 1'b0);
    pulse_ret(1'b1);
    chk(msr_q == (BIT_EE | BIT_CE | OTHER), "R9 state restored from critical pair",
        64'(msr_q), 64'(BIT_EE | BIT_CE | OTHER));
    drain("R10 retake after return");
    chk(norm_save_pc == 32'h3000_0000, "R10 normal retaken saved address", 64'(norm_save_pc), 64'h3000_0000);
    chk(msr_q == (BIT_CE | OTHER), "R10 EE cleared on retake", 64'(msr_q), 64'(BIT_CE | OTHER));
    ext_irq_in = 1'b0;
    tick(4);
    push(32'h3000_0000, 1'b0);
    pulse_ret(1'b0);
    drain("R8 second return");

    // R11 boundary gating
    insn_boundary = 1'b0;
    ext_irq_in    = 1'b1;
    tick(12);
    chk(norm_save_pc == 32'h3000_0000, "R11 no entry off boundary", 64'(norm_save_pc), 64'h3000_0000);
    next_pc = 32'h4000_0008;
    push(norm_vec(exc_base), 1'b0);
    insn_boundary = 1'b1;
    drain("R11 entry at boundary");
    chk(norm_save_pc == 32'h4000_0008, "R11 saved address at boundary", 64'(norm_save_pc), 64'h4000_0008);
    ext_irq_in = 1'b0;
    tick(4);
    push(32'h4000_0008, 1'b0);
    pulse_ret(1'b0);
    drain("R8 third return");

    // R1/R4/R6 critical latency and wrapping vector
    exc_base = 32'hFFFF_F800;
    next_pc  = 32'h5000_0040;
    push(crit_vec(32'hFFFF_F800), 1'b1);
    @(negedge clk);
    crit_irq_in = 1'b1;
    wait_redirect(lat);
    chk(lat == 4, "R1 critical entry latency", 64'(lat), 64'd4);
    chk(crit_vec(32'hFFFF_F800) == 32'h0000_0200, "R4 wrapped vector restated",
        64'(crit_vec(32'hFFFF_F800)), 64'h200);
    crit_irq_in = 1'b0;
    tick(4);
    push(32'h5000_0040, 1'b0);
    pulse_ret(1'b1);
    drain("R9 critical return");
    chk(msr_q == (BIT_EE | BIT_CE | OTHER), "R9 enables restored",
        64'(msr_q), 64'(BIT_EE | BIT_CE | OTHER));

    tick(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule